// File: doc/BRIEF.md
# Serial Configuration Bitstream Loader

This block loads a target FPGA through its slave-serial configuration pins. A host pulses `start_i` with the image length in bytes. The loader then holds the target's program pin low for a programmable reset interval and releases it. It waits for the target's initialisation pin to go low and then high again. After that it takes image bytes one at a time over a valid/ready handshake and shifts each one out, most significant bit first, on a serial clock derived from the system clock.

Each data bit is placed on the data line while the serial clock is low, so the target captures it on the next rising edge. Once the last image bit is sent, the loader keeps the serial clock running with the data line held high until the target reports completion. It then adds a fixed tail of extra clock cycles and stops the clock low. The status pins show whether a load is in progress, finished cleanly or was abandoned with an error. Both target status inputs pass through two-flop synchronisers before any decision is made on them.

Top module: `cfg_ldr`

## Requirements
- R1: On an accepted start, `prog_b_o` goes low and `cclk_o` stays low for exactly POR_CYCLES system cycles. After that `prog_b_o` returns high.
- R2: No rising edge appears on `cclk_o` until the synchronised `init_b_i` has been seen low and then high. If `init_b_i` does not return high within INIT_TIMEOUT cycles after `prog_b_o` is released, the load ends with `err_o` high and no clock edges.
- R3: The serial clock high and low halves each last HALF_DIV system cycles while it runs. `din_o` changes only while `cclk_o` is low. Each bit, the first included, is on `din_o` at least HALF_DIV cycles before the rising edge that samples it.
- R4: Image bytes are sent in the order they are accepted, bit 7 first. `byte_ready_o` is high only while `cclk_o` is low, once the previous byte's bit 0 has been clocked out. A byte is taken in the cycle where `byte_valid_i` and `byte_ready_o` are both high.
- R5: After the last image bit, every further rising edge of `cclk_o` sees `din_o` = 1.
- R6: After the synchronised `done_i` is seen high, exactly TAIL_CYCLES more rising edges occur. The clock then stops low, `busy_o` falls and `done_o` rises.
- R7: If `init_b_i` falls while bytes are being fetched, shifted or trailed, the loader stops the clock, drops `busy_o` and raises `err_o`.
- R8: If `done_i` is not seen within DONE_TIMEOUT rising edges after the data, the load ends with `err_o` high. This happens on the falling edge after the DONE_TIMEOUT-th trailing rise.
- R9: A start with `len_i` = 0 skips the data phase. It goes straight from the initialisation handshake to clocking with `din_o` = 1.
- R10: A start pulse while `busy_o` is high has no effect on the load in progress, its length or its data.
- R11: `done_o` and `err_o` are never high together. Both are low while `busy_o` is high, and each holds its value after a load until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a load when idle |
| len_i | input | LEN_W | Image length in bytes, sampled at start |
| byte_i | input | 8 | Image byte offered by the host |
| byte_valid_i | input | 1 | `byte_i` holds a valid byte |
| byte_ready_o | output | 1 | Loader will take a byte this cycle |
| prog_b_o | output | 1 | Active-low program request to the target |
| cclk_o | output | 1 | Serial configuration clock |
| din_o | output | 1 | Serial configuration data |
| init_b_i | input | 1 | Target initialisation status, asynchronous |
| done_i | input | 1 | Target configuration complete, asynchronous |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load completed with its tail |
| err_o | output | 1 | Last load was abandoned |

## Verification
Two events in the trailer can fall on the same cycle: the synchronised DONE arriving, and the clock divider producing a rising edge. That rise must count toward the tail exactly once. The bench model raises DONE on a chosen rising edge at several offsets past the data. It judges the result by counting the rising edges seen after DONE, which must equal TAIL_CYCLES. A second case pulses start during an active load and checks that the data, the edge count and the status still match the original length.

// File: rtl/cfg_ldr_pkg.sv
`timescale 1ns/1ps
package cfg_ldr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POR,
        ST_WAIT_INIT,
        ST_FETCH,
        ST_SHIFT,
        ST_TRAIL,
        ST_TAIL
    } ldr_state_e;

    function automatic int ldr_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfg_ldr_sync.sv
`timescale 1ns/1ps
module cfg_ldr_sync #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[g] <= RST_VAL[g];
                stab_q[g] <= RST_VAL[g];
            end else begin
                meta_q[g] <= d_i[g];
                stab_q[g] <= meta_q[g];
            end
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/cfg_ldr_clkgen.sv
`timescale 1ns/1ps
module cfg_ldr_clkgen #(
    parameter int HALF_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_now,
    input  logic run_next,
    output logic cclk_o,
    output logic rise_o,
    output logic fall_o
);

    localparam int            CW   = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          cclk_d, cclk_q;
    logic          turn;

    always_comb begin
        turn   = run_now && (cnt_q == LAST);
        cnt_d  = cnt_q;
        cclk_d = cclk_q;
        if (!run_next || !run_now) begin
            cnt_d  = '0;
            cclk_d = 1'b0;
        end else if (turn) begin
            cnt_d  = '0;
            cclk_d = ~cclk_q;
        end else begin
            cnt_d  = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            cclk_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            cclk_q <= cclk_d;
        end
    end

    assign cclk_o = cclk_q;
    assign rise_o = turn && !cclk_q;
    assign fall_o = turn && cclk_q;

    AST_HALF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_now && run_next && cnt_q != LAST) |=> $stable(cclk_q)); // R3

endmodule

// File: rtl/cfg_ldr.sv
`timescale 1ns/1ps
module cfg_ldr
    import cfg_ldr_pkg::*;
#(
    parameter int LEN_W        = 24,
    parameter int HALF_DIV     = 25,
    parameter int POR_CYCLES   = 5000000,
    parameter int INIT_TIMEOUT = 500000,
    parameter int DONE_TIMEOUT = 100000,
    parameter int TAIL_CYCLES  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [7:0]       byte_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             prog_b_o,
    output logic             cclk_o,
    output logic             din_o,
    input  logic             init_b_i,
    input  logic             done_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);

    localparam int CNT_MAX = ldr_max(ldr_max(POR_CYCLES, INIT_TIMEOUT),
                                     ldr_max(DONE_TIMEOUT, TAIL_CYCLES + 1));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] INIT_LAST = CNT_W'(INIT_TIMEOUT - 1);
    localparam logic [CNT_W-1:0] DONE_LIM  = CNT_W'(DONE_TIMEOUT);
    localparam logic [CNT_W-1:0] TAIL_LIM  = CNT_W'(TAIL_CYCLES);

    typedef struct packed {
        ldr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] left;
        logic [7:0]       sreg;
        logic [2:0]       bitn;
        logic             din;
        logic             prog_b;
        logic             seen_low;
        logic             done;
        logic             err;
    } ctl_t;

    ctl_t c_d, c_q;
    logic fail;
    logic init_s, done_s;
    logic rise, fall;
    logic run_now, run_next;

    cfg_ldr_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({done_i, init_b_i}),
        .q_o   ({done_s, init_s})
    );

    assign run_now  = (c_q.st == ST_SHIFT) || (c_q.st == ST_TRAIL) || (c_q.st == ST_TAIL);
    assign run_next = (c_d.st == ST_SHIFT) || (c_d.st == ST_TRAIL) || (c_d.st == ST_TAIL);

    cfg_ldr_clkgen #(
        .HALF_DIV (HALF_DIV)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_now  (run_now),
        .run_next (run_next),
        .cclk_o   (cclk_o),
        .rise_o   (rise),
        .fall_o   (fall)
    );

    always_comb begin
        c_d  = c_q;
        fail = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                c_d.prog_b = 1'b1;
                c_d.din    = 1'b1;
                if (start_i) begin
                    c_d.done     = 1'b0;
                    c_d.err      = 1'b0;
                    c_d.left     = len_i;
                    c_d.cnt      = '0;
                    c_d.seen_low = 1'b0;
                    c_d.prog_b   = 1'b0;
                    c_d.st       = ST_POR;
                end
            end
            ST_POR: begin
                if (!init_s) c_d.seen_low = 1'b1;
                if (c_q.cnt == POR_LAST) begin
                    c_d.cnt    = '0;
                    c_d.prog_b = 1'b1;
                    c_d.st     = ST_WAIT_INIT;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            ST_WAIT_INIT: begin
                if (!init_s) c_d.seen_low = 1'b1;
                if (c_q.seen_low && init_s) begin
                    c_d.cnt = '0;
                    if (c_q.left == '0) begin
                        c_d.din = 1'b1;
                        c_d.st  = ST_TRAIL;
                    end else begin
                        c_d.st  = ST_FETCH;
                    end
                end else if (c_q.cnt == INIT_LAST) begin
                    fail = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            ST_FETCH: begin
                if (!init_s) begin
                    fail = 1'b1;
                end else if (byte_valid_i) begin
                    c_d.sreg = byte_i;
                    c_d.din  = byte_i[7];
                    c_d.bitn = '0;
                    c_d.st   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (!init_s) begin
                    fail = 1'b1;
                end else if (fall) begin
                    if (c_q.bitn == 3'd7) begin
                        c_d.left = c_q.left - 1'b1;
                        if (c_q.left == LEN_W'(1)) begin
                            c_d.din = 1'b1;
                            c_d.cnt = '0;
                            c_d.st  = ST_TRAIL;
                        end else begin
                            c_d.st  = ST_FETCH;
                        end
                    end else begin
                        c_d.bitn = c_q.bitn + 1'b1;
                        c_d.din  = c_q.sreg[6];
                        c_d.sreg = {c_q.sreg[6:0], 1'b0};
                    end
                end
            end
            ST_TRAIL: begin
                if (!init_s) begin
                    fail = 1'b1;
                end else if (done_s) begin
                    c_d.cnt = rise ? CNT_W'(1) : '0;
                    c_d.st  = ST_TAIL;
                end else begin
                    if (rise) c_d.cnt = c_q.cnt + 1'b1;
                    if (fall && c_q.cnt >= DONE_LIM) fail = 1'b1;
                end
            end
            ST_TAIL: begin
                if (rise) c_d.cnt = c_q.cnt + 1'b1;
                if (fall && c_q.cnt == TAIL_LIM) begin
                    c_d.done = 1'b1;
                    c_d.cnt  = '0;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        if (fail) begin
            c_d.st     = ST_IDLE;
            c_d.err    = 1'b1;
            c_d.prog_b = 1'b1;
            c_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st       <= ST_IDLE;
            c_q.cnt      <= '0;
            c_q.left     <= '0;
            c_q.sreg     <= '0;
            c_q.bitn     <= '0;
            c_q.din      <= 1'b1;
            c_q.prog_b   <= 1'b1;
            c_q.seen_low <= 1'b0;
            c_q.done     <= 1'b0;
            c_q.err      <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign byte_ready_o = (c_q.st == ST_FETCH) && init_s;
    assign prog_b_o     = c_q.prog_b;
    assign din_o        = c_q.din;
    assign busy_o       = (c_q.st != ST_IDLE);
    assign done_o       = c_q.done;
    assign err_o        = c_q.err;

    AST_DIN_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cclk_o |-> $stable(din_o)); // R3
    AST_NO_CLK_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_b_o |-> !cclk_o); // R1
    AST_NO_CLK_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_POR || c_q.st == ST_WAIT_INIT) |-> !cclk_o); // R2
    AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (!cclk_o && prog_b_o)); // R4
    AST_TRAIL_DIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_TRAIL || c_q.st == ST_TAIL) |-> din_o); // R5
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o)); // R11
    AST_BUSY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!done_o && !err_o)); // R11
    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cclk_o); // R6

endmodule

// File: tb/cfg_ldr_bench.sv
`timescale 1ns/1ps
module cfg_ldr_bench;

    localparam int HALF  = 2;
    localparam int POR   = 20;
    localparam int INITT = 60;
    localparam int DONET = 30;
    localparam int TAIL  = 8;

    logic       clk, rst_n, start_i;
    logic [7:0] len_i, byte_i;
    logic       byte_valid_i, byte_ready_o;
    logic       prog_b_o, cclk_o, din_o;
    logic       tgt_init, tgt_done;
    logic       busy_o, done_o, err_o;

    cfg_ldr #(
        .LEN_W (8), .HALF_DIV (HALF), .POR_CYCLES (POR),
        .INIT_TIMEOUT (INITT), .DONE_TIMEOUT (DONET), .TAIL_CYCLES (TAIL)
    ) u_cfg_ldr (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .len_i (len_i),
        .byte_i (byte_i), .byte_valid_i (byte_valid_i), .byte_ready_o (byte_ready_o),
        .prog_b_o (prog_b_o), .cclk_o (cclk_o), .din_o (din_o),
        .init_b_i (tgt_init), .done_i (tgt_done),
        .busy_o (busy_o), .done_o (done_o), .err_o (err_o)
    );

    // {byte0, byte1, byte2, expected stream, rises of trailer before DONE}
    localparam logic [55:0] VEC [4] = '{
        {8'hA5, 8'h3C, 8'h01, 24'hA53C01, 8'd3},
        {8'hFF, 8'h00, 8'h80, 24'hFF0080, 8'd1},
        {8'h5A, 8'hC3, 8'h7E, 24'h5AC37E, 8'd6},
        {8'h01, 8'h02, 8'hFE, 24'h0102FE, 8'd2}
    };

    int checks = 0, errors = 0;
    int rises_total, trail_zero, post_done, por_cnt, early, half_bad, hi_run, idle_rises;
    int n_bits, tgt_done_at, init_dly_v, drop_at_v, icnt;
    logic drop_hold;
    logic [23:0] cap;
    logic [7:0] feed_mem [4];
    int feed_idx, feed_len;
    logic pend;

    initial begin
        clk = 0;
        forever #5 clk = ~clk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // host byte feeder
    initial begin
        byte_valid_i = 0; byte_i = 0; pend = 0; feed_idx = 0; feed_len = 0;
        forever begin
            @(negedge clk);
            if (pend) feed_idx++;
            byte_valid_i = (feed_idx < feed_len);
            byte_i = feed_mem[(feed_idx < 4) ? feed_idx : 0];
            pend = byte_ready_o && byte_valid_i;
        end
    end

    // target model: INIT_B handshake
    initial begin
        tgt_init = 1; icnt = 0;
        forever begin
            @(negedge clk);
            if (!prog_b_o) begin
                tgt_init = 0; icnt = 0;
            end else if (!tgt_init && !drop_hold) begin
                icnt++;
                if (icnt >= init_dly_v) tgt_init = 1;
            end
        end
    end

    // target model: bit capture and DONE
    initial begin
        forever begin
            @(posedge cclk_o);
            rises_total++;
            if (!busy_o) idle_rises++;
            if (!tgt_init && !drop_hold) early++;
            if (rises_total <= n_bits) cap = {cap[22:0], din_o};
            else if (!din_o) trail_zero++;
            if (tgt_done) post_done++;
            if (rises_total == tgt_done_at) tgt_done = 1;
            if (rises_total == drop_at_v) begin
                drop_hold = 1; tgt_init = 0;
            end
        end
    end

    // system-cycle monitor: program pulse length and clock high halves
    initial begin
        forever begin
            @(negedge clk);
            if (!prog_b_o) por_cnt++;
            if (cclk_o) hi_run++;
            else if (hi_run != 0) begin
                if (hi_run != HALF) half_bad++;
                hi_run = 0;
            end
        end
    end

    task automatic do_load(input int len, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] c, input int init_dly, input int done_at,
                           input int drop_at);
        int guard;
        rises_total = 0; cap = 0; trail_zero = 0; post_done = 0; por_cnt = 0;
        early = 0; half_bad = 0; hi_run = 0; idle_rises = 0;
        drop_hold = 0; drop_at_v = drop_at; tgt_done = 0; tgt_done_at = done_at;
        init_dly_v = init_dly; n_bits = len * 8;
        feed_mem[0] = a; feed_mem[1] = b; feed_mem[2] = c; feed_mem[3] = 8'h00;
        feed_idx = 0; feed_len = len; len_i = 8'(len);
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        chk("R11", "busy after start", int'(busy_o), 1);
        chk("R11", "flags clear while busy", int'(done_o | err_o), 0);
        guard = 0;
        while (busy_o && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        repeat (10) @(negedge clk);
    endtask

    initial begin
        rst_n = 0; start_i = 0; len_i = 0; tgt_done = 0; drop_hold = 0;
        drop_at_v = 0; init_dly_v = 6; n_bits = 0; tgt_done_at = 0;
        rises_total = 0; trail_zero = 0; post_done = 0; por_cnt = 0;
        early = 0; half_bad = 0; hi_run = 0; idle_rises = 0; cap = 0;
        repeat (3) @(negedge clk);
        chk("R11", "reset busy", int'(busy_o), 0);
        chk("R1",  "reset prog_b", int'(prog_b_o), 1);
        chk("R3",  "reset cclk", int'(cclk_o), 0);
        chk("R11", "reset flags", int'({done_o, err_o}), 0);
        chk("R4",  "reset ready", int'(byte_ready_o), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < 4; v++) begin
            do_load(3, VEC[v][55:48], VEC[v][47:40], VEC[v][39:32], 6 + v,
                    24 + int'(VEC[v][7:0]), 0);
            chk("R1",  "program pulse cycles", por_cnt, POR);
            chk("R2",  "edges before init", early, 0);
            chk("R3",  "bad high halves", half_bad, 0);
            chk("R4",  "captured stream", int'(cap), int'(VEC[v][31:8]));
            chk("R5",  "zero bits in trailer", trail_zero, 0);
            chk("R6",  "edges after done", post_done, TAIL);
            chk("R6",  "total edges", rises_total, 24 + int'(VEC[v][7:0]) + TAIL);
            chk("R6",  "edges while idle", idle_rises, 0);
            chk("R11", "done/err", int'({done_o, err_o}), 2);
        end

        repeat (30) @(negedge clk);
        chk("R11", "done holds", int'(done_o), 1);

        // single byte
        do_load(1, 8'hC5, 8'h00, 8'h00, 4, 8 + 4, 0);
        chk("R4", "single byte", int'(cap[7:0]), 8'hC5);
        chk("R6", "single byte done", int'(done_o), 1);

        // zero length
        do_load(0, 8'h00, 8'h00, 8'h00, 5, 3, 0);
        chk("R9", "zero len edges", rises_total, 3 + TAIL);
        chk("R9", "zero len din high", trail_zero, 0);
        chk("R9", "zero len done", int'(done_o), 1);

        // start while busy
        fork
            do_load(2, 8'h96, 8'h69, 8'h00, 6, 16 + 2, 0);
            begin
                wait (rises_total == 5);
                @(negedge clk); len_i = 8'd3; start_i = 1;
                @(negedge clk); start_i = 0;
            end
        join
        chk("R10", "data kept", int'(cap[15:0]), 16'h9669);
        chk("R10", "length kept", rises_total, 18 + TAIL);
        chk("R10", "still done", int'({done_o, err_o}), 2);

        // init never returns high
        do_load(2, 8'h11, 8'h22, 8'h00, 100000, 0, 0);
        chk("R2", "init timeout err", int'({done_o, err_o}), 1);
        chk("R2", "init timeout edges", rises_total, 0);
        chk("R2", "prog released", int'(prog_b_o), 1);

        // init drops during shifting
        do_load(3, 8'hAA, 8'h55, 8'hF0, 5, 40, 10);
        chk("R7", "init drop err", int'({done_o, err_o}), 1);
        chk("R7", "init drop busy", int'(busy_o), 0);
        chk("R7", "init drop edges", rises_total, 10);
        chk("R7", "init drop clock", int'(cclk_o), 0);

        // done never arrives
        do_load(1, 8'h3E, 8'h00, 8'h00, 5, 0, 0);
        chk("R8", "done timeout err", int'({done_o, err_o}), 1);
        chk("R8", "done timeout edges", rises_total, 8 + DONET);
        chk("R8", "done timeout data", int'(cap[7:0]), 8'h3E);
        repeat (20) @(negedge clk);
        chk("R11", "err holds", int'(err_o), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule